// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block accepts one interrupt message per cycle and works out which of its target controllers should receive it. A message carries an 8-bit destination, a bit choosing physical or logical addressing, a 3-bit delivery mode, a 2-bit shorthand, the table index of the sending controller, an 8-bit vector and the trigger and level bits. A per-target configuration table gives each controller its populated flag, its 8-bit ID, its 8-bit logical destination and a 4-bit destination-model nibble. Table sizes are set by a parameter, which may be anything up to 255 targets.

The resolved bitmask is then filtered by delivery mode into per-target strobes: fixed posting, SMI, NMI, INIT, startup and arbitration-ID load. For lowest-priority delivery the block picks the lowest-numbered selected target. It does no real arbitration. Every message produces its bitmask, strobes, vector and trigger bit together, two clock edges after it is accepted, marked by a single done pulse.

Top module: `intr_dest_resolver`

## Requirements
- R1: While reset is asserted and after its release, until a message is accepted, `res_done` and every output vector are zero.
- R2: A message accepted on `msg_valid` at clock edge k gives a one-cycle `res_done` after edge k+1, and one pulse per message, even back to back. When `res_done` is low, all mask, strobe, vector and trigger outputs are zero. When it is high, `res_vector` and `res_trig` carry the message's vector and trigger bit.
- R3: Physical mode (`msg_logical`=0) with shorthand 0: destination 0xFF selects every populated target. Any other destination selects only the lowest-index populated target whose ID equals it. If no target matches, it selects none.
- R4: Logical mode with shorthand 0: a target with model nibble 0xF (flat) is selected when its logical byte ANDed with the destination is non-zero.
- R5: Logical mode with shorthand 0: a target with model nibble 0x0 (cluster) is selected when the upper nibbles are equal and the lower nibbles share a set bit. A target with any other model value is never selected.
- R6: Shorthand 1 selects only the sender, 2 selects all targets and 3 selects all targets except the sender. In each case the destination byte and mode bit are ignored.
- R7: Unpopulated table entries never appear in `res_mask` or in any strobe.
- R8: Delivery mode 0 (fixed) sets `fixed_stb` equal to the resolved mask.
- R9: Delivery mode 1 (lowest priority) sets `fixed_stb` to the lowest-index bit of the resolved mask only.
- R10: Delivery modes 2 (SMI), 4 (NMI) and 5 (INIT) set `smi_stb`, `nmi_stb` or `init_stb` equal to the resolved mask.
- R11: INIT with level bit 0 and trigger bit 1 is a de-assert. It sets `arb_load` equal to the mask and raises no other strobe.
- R12: Delivery mode 6 (startup) sets `sipi_stb` equal to the mask.
- R13: Delivery modes 7 (external) and 3 (undefined) raise no strobe. `res_mask` still reports the resolved set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message present this cycle |
| msg_dest | input | 8 | Destination byte |
| msg_logical | input | 1 | 0 physical, 1 logical addressing |
| msg_dm | input | 3 | Delivery mode |
| msg_short | input | 2 | Destination shorthand |
| msg_sender | input | IDXW | Table index of the sending controller |
| msg_vector | input | 8 | Interrupt vector |
| msg_trig | input | 1 | Trigger bit (1 level) |
| msg_level | input | 1 | Level bit (INIT assert/de-assert) |
| tgt_valid | input | N_TGT | Populated flag per target |
| tgt_id | input | 8*N_TGT | ID per target |
| tgt_log | input | 8*N_TGT | Logical destination per target |
| tgt_model | input | 4*N_TGT | Destination-model nibble per target |
| res_done | output | 1 | Result valid pulse |
| res_mask | output | N_TGT | Resolved target set |
| res_vector | output | 8 | Vector of the resolved message |
| res_trig | output | 1 | Trigger bit of the resolved message |
| fixed_stb | output | N_TGT | Post vector to target |
| smi_stb | output | N_TGT | SMI to target |
| nmi_stb | output | N_TGT | NMI to target |
| init_stb | output | N_TGT | INIT to target |
| sipi_stb | output | N_TGT | Startup to target |
| arb_load | output | N_TGT | Copy ID into arbitration-ID register |

## Verification
Two resolutions can be in flight at once. The second stage filters one message's mask into strobes while the first stage decodes the destination of the next message. The bench provokes this by presenting messages on consecutive cycles, mixing addressing styles and delivery modes, for example a logical cluster INIT de-assert followed at once by a physical lowest-priority message. The behavioural model keeps its own two-deep queue of expected results and compares every output on every clock. A leak of state between the stages therefore shows up as a mismatch in either the mask or the strobe class of one of the two messages.

// File: rtl/intr_dest_pkg.sv
package intr_dest_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWPRI = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXT    = 3'd7
    } dlv_mode_e;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;
    localparam logic [7:0] DEST_BCAST    = 8'hFF;

endpackage

// File: rtl/intr_lowest_pick.sv
module intr_lowest_pick #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] onehot
);
    // isolate the least significant set bit
    always_comb begin
        onehot = vec & (~vec + W'(1));
    end
endmodule

// File: rtl/intr_dest_match.sv
module intr_dest_match
    import intr_dest_pkg::*;
#(
    parameter int N_TGT = 8
) (
    input  logic [7:0]         dest,
    input  logic               logical,
    input  logic [N_TGT-1:0]   tgt_valid,
    input  logic [8*N_TGT-1:0] tgt_id,
    input  logic [8*N_TGT-1:0] tgt_log,
    input  logic [4*N_TGT-1:0] tgt_model,
    output logic [N_TGT-1:0]   sel
);
    logic [N_TGT-1:0] id_hit;
    logic [N_TGT-1:0] id_first;
    logic [N_TGT-1:0] log_hit;

    for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
        logic [7:0] lb;
        logic [3:0] mdl;
        assign lb  = tgt_log[8*i +: 8];
        assign mdl = tgt_model[4*i +: 4];

        always_comb begin
            id_hit[i] = tgt_valid[i] && (tgt_id[8*i +: 8] == dest);
            unique case (mdl)
                MODEL_FLAT:    log_hit[i] = tgt_valid[i] && ((dest & lb) != 8'h00);
                MODEL_CLUSTER: log_hit[i] = tgt_valid[i] && (dest[7:4] == lb[7:4])
                                            && ((dest[3:0] & lb[3:0]) != 4'h0);
                default:       log_hit[i] = 1'b0;
            endcase
        end
    end

    intr_lowest_pick #(.W(N_TGT)) u_first_id (
        .vec    (id_hit),
        .onehot (id_first)
    );

    always_comb begin
        if (logical) begin
            sel = log_hit;
        end else if (dest == DEST_BCAST) begin
            sel = tgt_valid;
        end else begin
            sel = id_first;
        end
    end
endmodule

// File: rtl/intr_dest_resolver.sv
module intr_dest_resolver
    import intr_dest_pkg::*;
#(
    parameter int N_TGT = 8,
    localparam int IDXW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_valid,
    input  logic [7:0]         msg_dest,
    input  logic               msg_logical,
    input  logic [2:0]         msg_dm,
    input  logic [1:0]         msg_short,
    input  logic [IDXW-1:0]    msg_sender,
    input  logic [7:0]         msg_vector,
    input  logic               msg_trig,
    input  logic               msg_level,
    input  logic [N_TGT-1:0]   tgt_valid,
    input  logic [8*N_TGT-1:0] tgt_id,
    input  logic [8*N_TGT-1:0] tgt_log,
    input  logic [4*N_TGT-1:0] tgt_model,
    output logic               res_done,
    output logic [N_TGT-1:0]   res_mask,
    output logic [7:0]         res_vector,
    output logic               res_trig,
    output logic [N_TGT-1:0]   fixed_stb,
    output logic [N_TGT-1:0]   smi_stb,
    output logic [N_TGT-1:0]   nmi_stb,
    output logic [N_TGT-1:0]   init_stb,
    output logic [N_TGT-1:0]   sipi_stb,
    output logic [N_TGT-1:0]   arb_load
);
    typedef struct packed {
        // stage 1: resolved set plus message fields
        logic             s1_vld;
        logic [N_TGT-1:0] s1_mask;
        dlv_mode_e        s1_dm;
        logic [7:0]       s1_vec;
        logic             s1_trig;
        logic             s1_level;
        // stage 2: presented result
        logic             done;
        logic [N_TGT-1:0] mask;
        logic [7:0]       vec;
        logic             trig;
        logic [N_TGT-1:0] fix;
        logic [N_TGT-1:0] smi;
        logic [N_TGT-1:0] nmi;
        logic [N_TGT-1:0] ini;
        logic [N_TGT-1:0] sipi;
        logic [N_TGT-1:0] arb;
    } state_t;

    state_t st_d, st_q;

    logic [N_TGT-1:0] match_sel;
    logic [N_TGT-1:0] sender_oh;
    logic [N_TGT-1:0] low_oh;

    intr_dest_match #(.N_TGT(N_TGT)) u_match (
        .dest      (msg_dest),
        .logical   (msg_logical),
        .tgt_valid (tgt_valid),
        .tgt_id    (tgt_id),
        .tgt_log   (tgt_log),
        .tgt_model (tgt_model),
        .sel       (match_sel)
    );

    intr_lowest_pick #(.W(N_TGT)) u_lowpri (
        .vec    (st_q.s1_mask),
        .onehot (low_oh)
    );

    always_comb begin
        sender_oh = '0;
        for (int i = 0; i < N_TGT; i++) begin
            sender_oh[i] = (IDXW'(i) == msg_sender);
        end
    end

    always_comb begin
        st_d = '0;

        // stage 1: destination decode
        st_d.s1_vld   = msg_valid;
        st_d.s1_dm    = dlv_mode_e'(msg_dm);
        st_d.s1_vec   = msg_vector;
        st_d.s1_trig  = msg_trig;
        st_d.s1_level = msg_level;
        if (msg_valid) begin
            unique case (shorthand_e'(msg_short))
                SH_SELF:   st_d.s1_mask = sender_oh & tgt_valid;
                SH_ALL:    st_d.s1_mask = tgt_valid;
                SH_OTHERS: st_d.s1_mask = tgt_valid & ~sender_oh;
                default:   st_d.s1_mask = match_sel;
            endcase
        end

        // stage 2: delivery-mode filter
        st_d.done = st_q.s1_vld;
        if (st_q.s1_vld) begin
            st_d.mask = st_q.s1_mask;
            st_d.vec  = st_q.s1_vec;
            st_d.trig = st_q.s1_trig;
            unique case (st_q.s1_dm)
                DM_FIXED:  st_d.fix  = st_q.s1_mask;
                DM_LOWPRI: st_d.fix  = low_oh;
                DM_SMI:    st_d.smi  = st_q.s1_mask;
                DM_NMI:    st_d.nmi  = st_q.s1_mask;
                DM_INIT: begin
                    if (!st_q.s1_level && st_q.s1_trig) begin
                        st_d.arb = st_q.s1_mask;
                    end else begin
                        st_d.ini = st_q.s1_mask;
                    end
                end
                DM_START:  st_d.sipi = st_q.s1_mask;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_done   = st_q.done;
    assign res_mask   = st_q.mask;
    assign res_vector = st_q.vec;
    assign res_trig   = st_q.trig;
    assign fixed_stb  = st_q.fix;
    assign smi_stb    = st_q.smi;
    assign nmi_stb    = st_q.nmi;
    assign init_stb   = st_q.ini;
    assign sipi_stb   = st_q.sipi;
    assign arb_load   = st_q.arb;
endmodule

// File: rtl/intr_dest_resolver_chk.sv
module intr_dest_resolver_chk #(
    parameter int N_TGT = 8,
    localparam int IDXW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic [2:0]         msg_dm,
    input logic [N_TGT-1:0]   tgt_valid,
    input logic               res_done,
    input logic [N_TGT-1:0]   res_mask,
    input logic [7:0]         res_vector,
    input logic               res_trig,
    input logic [N_TGT-1:0]   fixed_stb,
    input logic [N_TGT-1:0]   smi_stb,
    input logic [N_TGT-1:0]   nmi_stb,
    input logic [N_TGT-1:0]   init_stb,
    input logic [N_TGT-1:0]   sipi_stb,
    input logic [N_TGT-1:0]   arb_load
);
    logic [1:0] cyc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    logic [N_TGT-1:0] any_stb;
    assign any_stb = fixed_stb | smi_stb | nmi_stb | init_stb | sipi_stb | arb_load;

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ##2 res_done);

    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> (res_mask == '0 && any_stb == '0 && res_vector == 8'h00 && !res_trig));

    a_r7_no_unpopulated: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> ((res_mask & ~$past(tgt_valid, 2)) == '0));

    a_r10_strobe_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb & ~res_mask) == '0);

    a_r9_lowpri_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && $past(msg_valid, 2) && $past(msg_dm, 2) == 3'd1) |-> $onehot0(fixed_stb));

    a_r11_deassert_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !((|arb_load) && (|(init_stb | fixed_stb | smi_stb | nmi_stb | sipi_stb))));
endmodule

bind intr_dest_resolver intr_dest_resolver_chk #(.N_TGT(N_TGT)) u_chk (.*);

// File: tb/intr_dest_resolver_bench.sv
module intr_dest_resolver_bench;
    localparam int NT = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic          msg_valid = 1'b0;
    logic [7:0]    msg_dest = 8'h00;
    logic          msg_logical = 1'b0;
    logic [2:0]    msg_dm = 3'd0;
    logic [1:0]    msg_short = 2'd0;
    logic [IW-1:0] msg_sender = '0;
    logic [7:0]    msg_vector = 8'h00;
    logic          msg_trig = 1'b0;
    logic          msg_level = 1'b0;
    logic [NT-1:0]   tgt_valid;
    logic [8*NT-1:0] tgt_id;
    logic [8*NT-1:0] tgt_log;
    logic [4*NT-1:0] tgt_model;

    logic          res_done;
    logic [NT-1:0] res_mask, fixed_stb, smi_stb, nmi_stb, init_stb, sipi_stb, arb_load;
    logic [7:0]    res_vector;
    logic          res_trig;

    intr_dest_resolver #(.N_TGT(NT)) u_intr_dest_resolver (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_dest(msg_dest),
        .msg_logical(msg_logical), .msg_dm(msg_dm), .msg_short(msg_short),
        .msg_sender(msg_sender), .msg_vector(msg_vector), .msg_trig(msg_trig),
        .msg_level(msg_level), .tgt_valid(tgt_valid), .tgt_id(tgt_id),
        .tgt_log(tgt_log), .tgt_model(tgt_model), .res_done(res_done),
        .res_mask(res_mask), .res_vector(res_vector), .res_trig(res_trig),
        .fixed_stb(fixed_stb), .smi_stb(smi_stb), .nmi_stb(nmi_stb),
        .init_stb(init_stb), .sipi_stb(sipi_stb), .arb_load(arb_load)
    );

    typedef struct packed {
        logic          done;
        logic [NT-1:0] mask, fix, smi, nmi, ini, sipi, arb;
        logic [7:0]    vec;
        logic          trig;
    } exp_t;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";

    // behavioural reference of one message
    function automatic exp_t model();
        exp_t e = '0;
        logic [NT-1:0] m = '0;
        bit found = 0;
        for (int i = 0; i < NT; i++) begin
            logic [7:0] idb = tgt_id[8*i +: 8];
            logic [7:0] lb  = tgt_log[8*i +: 8];
            logic [3:0] md  = tgt_model[4*i +: 4];
            if (!tgt_valid[i]) continue;
            case (msg_short)
                2'd1: m[i] = (i == int'(msg_sender));
                2'd2: m[i] = 1'b1;
                2'd3: m[i] = (i != int'(msg_sender));
                default: begin
                    if (!msg_logical) begin
                        if (msg_dest == 8'hFF) m[i] = 1'b1;
                        else if (!found && idb == msg_dest) begin m[i] = 1'b1; found = 1; end
                    end else if (md == 4'hF) begin
                        m[i] = (msg_dest & lb) != 0;
                    end else if (md == 4'h0) begin
                        m[i] = (msg_dest[7:4] == lb[7:4]) && ((msg_dest[3:0] & lb[3:0]) != 0);
                    end
                end
            endcase
        end
        e.done = 1'b1;
        e.mask = m;
        e.vec  = msg_vector;
        e.trig = msg_trig;
        case (msg_dm)
            3'd0: e.fix = m;
            3'd1: begin
                for (int i = 0; i < NT; i++) if (m[i]) begin e.fix[i] = 1'b1; break; end
            end
            3'd2: e.smi = m;
            3'd4: e.nmi = m;
            3'd5: if (!msg_level && msg_trig) e.arb = m; else e.ini = m;
            3'd6: e.sipi = m;
            default: ;
        endcase
        return e;
    endfunction

    exp_t exp_p1 = '0, exp_p2 = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_p1 = '0;
            exp_p2 = '0;
        end else begin
            exp_p2 = exp_p1;
            exp_p1 = msg_valid ? model() : '0;
        end
    end

    exp_t act;
    assign act = '{res_done, res_mask, fixed_stb, smi_stb, nmi_stb, init_stb,
                   sipi_stb, arb_load, res_vector, res_trig};

    always @(negedge clk) begin
        tests++;
        if (act !== exp_p2) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", cur_req, act, exp_p2);
        end
    end

    task automatic put(input logic [7:0] d, input logic lg, input logic [2:0] dm,
                       input logic [1:0] sh, input int snd, input logic [7:0] v,
                       input logic tr, input logic lv);
        msg_valid = 1'b1; msg_dest = d; msg_logical = lg; msg_dm = dm;
        msg_short = sh; msg_sender = IW'(snd); msg_vector = v;
        msg_trig = tr; msg_level = lv;
        @(negedge clk);
    endtask

    task automatic idle();
        msg_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // table: idx3 duplicates idx2's ID, idx7 unpopulated, idx6 odd model
        tgt_valid = 8'b0111_1111;
        tgt_id    = {8'h07, 8'h22, 8'h21, 8'h20, 8'h05, 8'h05, 8'h02, 8'h01};
        tgt_log   = {8'hFF, 8'hFF, 8'h43, 8'h32, 8'h31, 8'h84, 8'h02, 8'h01};
        tgt_model = {4'hF, 4'h5, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF};

        cur_req = "R1";
        repeat (3) @(negedge clk);
        tests++;
        if (res_done !== 1'b0 || res_mask !== '0) begin
            fails++;
            $display("FAIL R1: actual %b/%h expected 0/00", res_done, res_mask);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R3"; // physical broadcast, duplicate ID, unpopulated ID, no match
        put(8'hFF, 0, 3'd0, 2'd0, 0, 8'h31, 0, 1); idle();
        put(8'h05, 0, 3'd0, 2'd0, 0, 8'h32, 1, 1); idle();
        put(8'h99, 0, 3'd0, 2'd0, 0, 8'h33, 0, 1); idle();
        cur_req = "R7";
        put(8'h07, 0, 3'd0, 2'd0, 0, 8'h34, 0, 1); idle();

        cur_req = "R4"; // flat logical
        put(8'h03, 1, 3'd0, 2'd0, 0, 8'h40, 0, 1); idle();
        put(8'h84, 1, 3'd0, 2'd0, 0, 8'h41, 0, 1); idle();

        cur_req = "R5"; // cluster logical, odd model never
        put(8'h33, 1, 3'd0, 2'd0, 0, 8'h50, 0, 1); idle();
        put(8'h44, 1, 3'd0, 2'd0, 0, 8'h51, 0, 1); idle();
        put(8'h43, 1, 3'd0, 2'd0, 0, 8'h52, 0, 1); idle();

        cur_req = "R6"; // shorthands ignore destination
        put(8'h00, 1, 3'd0, 2'd1, 3, 8'h60, 0, 1); idle();
        put(8'h00, 0, 3'd0, 2'd2, 3, 8'h61, 0, 1); idle();
        put(8'h01, 0, 3'd0, 2'd3, 0, 8'h62, 0, 1); idle();
        cur_req = "R7";
        put(8'h00, 0, 3'd0, 2'd1, 7, 8'h63, 0, 1); idle();
        put(8'hFF, 0, 3'd2, 2'd2, 7, 8'h64, 0, 1); idle();

        cur_req = "R8";
        put(8'h33, 1, 3'd0, 2'd0, 0, 8'h70, 1, 1); idle();
        cur_req = "R9";
        put(8'h33, 1, 3'd1, 2'd0, 0, 8'h71, 0, 1); idle();
        put(8'h22, 0, 3'd1, 2'd0, 0, 8'h72, 0, 1); idle();
        put(8'h01, 0, 3'd1, 2'd3, 0, 8'h73, 0, 1); idle();
        cur_req = "R10";
        put(8'hFF, 0, 3'd2, 2'd0, 0, 8'h00, 0, 1); idle();
        put(8'h03, 1, 3'd4, 2'd0, 0, 8'h00, 0, 1); idle();
        put(8'hFF, 0, 3'd5, 2'd0, 0, 8'h00, 0, 1); idle();
        put(8'hFF, 0, 3'd5, 2'd0, 0, 8'h00, 1, 1); idle();
        cur_req = "R11";
        put(8'hFF, 0, 3'd5, 2'd0, 0, 8'h00, 1, 0); idle();
        put(8'h33, 1, 3'd5, 2'd3, 2, 8'h00, 1, 0); idle();
        cur_req = "R12";
        put(8'h05, 0, 3'd6, 2'd0, 0, 8'h9A, 0, 1); idle();
        cur_req = "R13";
        put(8'hFF, 0, 3'd7, 2'd0, 0, 8'hA0, 0, 1); idle();
        put(8'hFF, 0, 3'd3, 2'd0, 0, 8'hA1, 1, 1); idle();

        cur_req = "R2"; // back-to-back, mixed modes overlapping in the pipeline
        put(8'h33, 1, 3'd5, 2'd0, 0, 8'hB0, 1, 0);
        put(8'h05, 0, 3'd1, 2'd0, 0, 8'hB1, 0, 1);
        put(8'hFF, 0, 3'd6, 2'd3, 4, 8'hB2, 1, 1);
        put(8'h84, 1, 3'd4, 2'd0, 0, 8'hB3, 0, 1);
        put(8'h44, 1, 3'd0, 2'd0, 0, 8'hB4, 1, 1);
        idle();
        for (int k = 0; k < 40; k++) begin
            put(8'(k * 37), 1'(k % 2), 3'(k), 2'(k / 7), k % 8, 8'(k), 1'(k / 3), 1'(k / 5));
        end
        idle();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule